// File: doc/BRIEF.md
# Low-Frequency Edge Window Filter

This block screens the rising edges of a slow reference clock before a phase detector sees them. The reference runs at 2 kHz, 4 kHz or 8 kHz, and a rate select tells the block which. While filtering is switched on, an edge is passed only when it lands late enough after the last edge that was passed. That point is 95% of the nominal period, counted in system clock cycles. An edge that comes too early is treated as noise, such as contact bounce while a cable is being pulled, and is dropped. A dropped edge does not move the timing reference, so the next good edge is still judged against the last good one.

The time window runs from 95% to 105% of the nominal period. If no edge arrives by the 105% point, the filter re-arms and takes whatever edge comes next. The filter therefore cannot lock itself out. The first edge after reset, after filtering is switched on, or after a change of rate select is always taken. This edge starts the timer. The output is a registered pulse one system clock wide for every edge that passes. With filtering off, or with the "no low-frequency rate" select, every edge passes.

Top module: `lfw_edge_window`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `edge_ok` is low. The first rising edge of `ref_in` after reset is passed whatever its timing.
- R2: A rising edge is `ref_in` sampled high at a `clk` edge after being sampled low at the previous one. It gives `edge_ok` high for exactly one cycle, starting at the second `clk` edge after that sample. `edge_ok` is never high except for such an edge.
- R3: When `win_en` is 0, or `freq_sel` is 2'b11 (no low-frequency rate), every rising edge passes.
- R4: `freq_sel` 2'b00, 2'b01 and 2'b10 select 2, 4 and 8 kHz. The nominal period is P = SYS_CLK_HZ / (2000 * 2^freq_sel) cycles. The bounds are LO = floor(95*P/100) and HI = ceil(105*P/100). An interval is the number of `clk` cycles between two rising edges as sampled. An edge at an interval of exactly LO or exactly HI passes.
- R5: With filtering active, an edge less than LO cycles after the last passed edge is dropped and produces no pulse.
- R6: A dropped edge does not restart the interval. The next edge is measured from the last passed edge.
- R7: The first edge after `win_en` goes from 0 to 1, or after any change of `freq_sel`, passes whatever its interval.
- R8: If HI cycles elapse after a passed edge without another passed edge, the next edge passes. Every passed edge restarts the interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Low-frequency reference, already synchronized to `clk` |
| freq_sel | input | 2 | Reference rate: 00 = 2 kHz, 01 = 4 kHz, 10 = 8 kHz, 11 = no low-frequency rate |
| win_en | input | 1 | 1 turns on the edge window filter |
| edge_ok | output | 1 | One-cycle pulse for each edge that passes |

## Verification
On every cycle, the assertions check the following:
- the output is quiet during reset;
- each pulse is one cycle wide and follows a detected edge;
- in bypass every edge reaches the output;
- with filtering active an early edge gives no pulse;
- a pulse always comes with a restarted timer;
- enabling or changing the rate re-arms the filter.

Whether a dropped edge leaves the interval measured from the last passed edge, and how the exact LO and HI boundaries behave, can only be shown by the bench. The bench does this through its sequences of spaced edges, with bounds it computes from the rate select.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

  localparam int NUM_SEL  = 4;
  localparam int BASE_HZ  = 2000;
  localparam int PCT_LO   = 95;
  localparam int PCT_HI   = 105;

  typedef enum logic [1:0] {
    RATE_2K   = 2'd0,
    RATE_4K   = 2'd1,
    RATE_8K   = 2'd2,
    RATE_NONE = 2'd3
  } rate_e;

  // nominal reference period in system clock cycles
  function automatic int nominal_cycles(input int clk_hz, input int sel);
    return clk_hz / (BASE_HZ << sel);
  endfunction

  // earliest acceptable interval, rounded down
  function automatic int lower_cycles(input int clk_hz, input int sel);
    return (nominal_cycles(clk_hz, sel) * PCT_LO) / 100;
  endfunction

  // latest in-window interval, rounded up
  function automatic int upper_cycles(input int clk_hz, input int sel);
    return (nominal_cycles(clk_hz, sel) * PCT_HI + 99) / 100;
  endfunction

  // the counter must reach one past the widest upper bound
  function automatic int count_width(input int clk_hz);
    return $clog2(upper_cycles(clk_hz, 0) + 2);
  endfunction

endpackage

// File: rtl/lfw_rise_detect.sv
module lfw_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic prev_q;

  // prev resets high so a level already high at release is not an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      rise   <= 1'b0;
    end else begin
      prev_q <= din;
      rise   <= din & ~prev_q;
    end
  end

endmodule

// File: rtl/lfw_bounds.sv
module lfw_bounds
  import lfw_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int CW         = 16
) (
  input  logic [1:0]    sel,
  output logic [CW-1:0] lo,
  output logic [CW-1:0] hi,
  output logic          bypass
);

  logic [CW-1:0] lo_tab [NUM_SEL];
  logic [CW-1:0] hi_tab [NUM_SEL];

  generate
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_rate
      if (g == int'(RATE_NONE)) begin : g_open
        assign lo_tab[g] = '0;
        assign hi_tab[g] = '1;
      end else begin : g_win
        assign lo_tab[g] = CW'(lower_cycles(SYS_CLK_HZ, g));
        assign hi_tab[g] = CW'(upper_cycles(SYS_CLK_HZ, g));
      end
    end
  endgenerate

  assign lo     = lo_tab[sel];
  assign hi     = hi_tab[sel];
  assign bypass = (sel == RATE_NONE);

endmodule

// File: rtl/lfw_interval_timer.sv
module lfw_interval_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  // counts cycles since the last passed edge, saturating at the top
  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (restart)        cnt <= CNT_ONE;
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
  end

endmodule

// File: rtl/lfw_edge_gate.sv
module lfw_edge_gate #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          win_en,
  input  logic [1:0]    freq_sel,
  input  logic [CW-1:0] lo,
  input  logic [CW-1:0] hi,
  input  logic          bypass,
  input  logic [CW-1:0] cnt,
  output logic          accept,
  output logic          fresh,
  output logic          edge_ok
);

  logic       en_q;
  logic [1:0] sel_q;
  logic       rearm;
  logic       in_window;

  // history of the controls, kept running through reset
  always_ff @(posedge clk) begin
    en_q  <= win_en;
    sel_q <= freq_sel;
  end

  assign rearm     = (win_en & ~en_q) | (freq_sel != sel_q);
  assign in_window = (cnt >= lo) & (cnt <= hi);
  assign accept    = rise & (~win_en | bypass | fresh | in_window);

  // fresh: the next edge is taken unconditionally
  always_ff @(posedge clk) begin
    if (rst)         fresh <= 1'b1;
    else if (rearm)  fresh <= 1'b1;
    else if (accept) fresh <= 1'b0;
    else if (cnt == hi) fresh <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) edge_ok <= 1'b0;
    else     edge_ok <= accept;
  end

endmodule

// File: rtl/lfw_edge_window.sv
module lfw_edge_window
  import lfw_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_in,
  input  logic [1:0] freq_sel,
  input  logic       win_en,
  output logic       edge_ok
);

  localparam int CW = count_width(SYS_CLK_HZ);

  logic          rise_q;
  logic [CW-1:0] lo_b;
  logic [CW-1:0] hi_b;
  logic          bypass_b;
  logic [CW-1:0] tmr_cnt;
  logic          accept_c;
  logic          fresh_q;

  lfw_rise_detect u_rise (
    .clk  (clk),
    .rst  (rst),
    .din  (ref_in),
    .rise (rise_q)
  );

  lfw_bounds #(
    .SYS_CLK_HZ (SYS_CLK_HZ),
    .CW         (CW)
  ) u_bounds (
    .sel    (freq_sel),
    .lo     (lo_b),
    .hi     (hi_b),
    .bypass (bypass_b)
  );

  lfw_interval_timer #(
    .CW (CW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (accept_c),
    .cnt     (tmr_cnt)
  );

  lfw_edge_gate #(
    .CW (CW)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise_q),
    .win_en   (win_en),
    .freq_sel (freq_sel),
    .lo       (lo_b),
    .hi       (hi_b),
    .bypass   (bypass_b),
    .cnt      (tmr_cnt),
    .accept   (accept_c),
    .fresh    (fresh_q),
    .edge_ok  (edge_ok)
  );

endmodule

// File: rtl/lfw_edge_window_chk.sv
module lfw_edge_window_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          win_en,
  input logic [1:0]    freq_sel,
  input logic          edge_ok,
  input logic          rise,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lo,
  input logic          fresh
);

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !edge_ok)
    else $error("reset did not silence edge_ok");

  p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    edge_ok |=> !edge_ok)
    else $error("edge_ok wider than one cycle");

  p_from_rise_r2: assert property (@(posedge clk) disable iff (rst)
    edge_ok |-> $past(rise))
    else $error("edge_ok without a detected edge");

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (rise && (!win_en || freq_sel == 2'b11)) |=> edge_ok)
    else $error("bypass edge not passed");

  p_early_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (rise && win_en && freq_sel != 2'b11 && !fresh && cnt < lo) |=> !edge_ok)
    else $error("early edge passed");

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    edge_ok |-> (cnt == CW'(1)))
    else $error("passed edge did not restart timer");

  p_rearm_en_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(win_en) |=> fresh)
    else $error("enable did not re-arm");

  p_rearm_sel_r7: assert property (@(posedge clk) disable iff (rst)
    (freq_sel != $past(freq_sel)) |=> fresh)
    else $error("rate change did not re-arm");

endmodule

bind lfw_edge_window lfw_edge_window_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .win_en   (win_en),
  .freq_sel (freq_sel),
  .edge_ok  (edge_ok),
  .rise     (rise_q),
  .cnt      (tmr_cnt),
  .lo       (lo_b),
  .fresh    (fresh_q)
);

// File: tb/lfw_edge_window_test.sv
module lfw_edge_window_test;

  localparam int SYS_HZ = 400_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_in = 1'b0;
  logic [1:0] freq_sel = 2'b00;
  logic       win_en = 1'b0;
  logic       edge_ok;

  lfw_edge_window #(.SYS_CLK_HZ(SYS_HZ)) uut (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (ref_in),
    .freq_sel (freq_sel),
    .win_en   (win_en),
    .edge_ok  (edge_ok)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    exp;
    string tag;
  } item_t;

  item_t sbq[$];
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  int    last_drv = 0;
  int    last_acc = 0;
  bit    m_fresh = 1'b1;

  function automatic int per_of(int s);
    return SYS_HZ / (2000 << s);
  endfunction
  function automatic int lo_of(int s);
    return (per_of(s) * 95) / 100;
  endfunction
  function automatic int hi_of(int s);
    return (per_of(s) * 105 + 99) / 100;
  endfunction

  // monitor: compare scheduled expectations, flag any stray pulse
  always @(negedge clk) begin
    if (!done) begin
      if (sbq.size() > 0 && sbq[0].at == cyc) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (edge_ok !== it.exp) begin
          bad++;
          $display("FAIL %s cycle %0d: edge_ok=%b expected %b", it.tag, cyc, edge_ok, it.exp);
        end
      end else if (edge_ok !== 1'b0) begin
        total++;
        bad++;
        $display("FAIL R2 cycle %0d: edge_ok=%b expected 0 (no pending edge)", cyc, edge_ok);
      end
    end
  end

  // driver: one-cycle high pulse on ref_in, gap cycles after the previous one
  task automatic send(input int gap, input string tag);
    int  target;
    int  iv;
    bit  acc;
    target = last_drv + gap;
    while (cyc < target) @(negedge clk);
    ref_in = 1'b1;
    last_drv = cyc;
    iv = cyc - last_acc;
    acc = !win_en || (freq_sel == 2'b11) || m_fresh ||
          (iv >= lo_of(freq_sel)) || (iv > hi_of(freq_sel));
    if (acc) begin
      last_acc = cyc;
      m_fresh  = 1'b0;
    end
    sbq.push_back('{at: cyc + 2, exp: acc, tag: tag});
    @(negedge clk);
    ref_in = 1'b0;
  endtask

  task automatic set_mode(input bit en, input logic [1:0] s);
    @(negedge clk);
    if ((en && !win_en) || (s != freq_sel)) m_fresh = 1'b1;
    win_en   = en;
    freq_sel = s;
    repeat (3) @(negedge clk);
    last_drv = cyc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, pending=%0d expected 0", sbq.size());
    finish_run();
  end

  initial begin
    // R1: quiet during reset
    repeat (4) begin
      @(negedge clk);
      total++;
      if (edge_ok !== 1'b0) begin
        bad++;
        $display("FAIL R1 reset: edge_ok=%b expected 0", edge_ok);
      end
    end
    rst = 1'b0;
    last_drv = cyc;
    last_acc = cyc;
    m_fresh  = 1'b1;

    // 2 kHz window: LO=190 HI=210
    set_mode(1'b1, 2'b00);
    send(20,  "R1 first edge");
    send(200, "R4 nominal 2k");
    send(190, "R4 lower bound 2k");
    send(189, "R5 early by one 2k");
    send(21,  "R6 measured from last pass (210)");
    send(211, "R8 late after HI");
    send(5,   "R5 bounce");
    send(195, "R6 after bounce (200)");
    send(300, "R8 long gap");

    // 4 kHz window: LO=95 HI=105
    set_mode(1'b1, 2'b01);
    send(10,  "R7 rate change 4k");
    send(93,  "R5 early 4k");
    send(2,   "R4 lower bound 4k (95)");
    send(105, "R4 upper bound 4k");
    send(50,  "R5 mid bounce 4k");
    send(56,  "R8 late 4k (106)");

    // 8 kHz window: LO=47 HI=53
    set_mode(1'b1, 2'b10);
    send(10,  "R7 rate change 8k");
    send(46,  "R5 early 8k");
    send(7,   "R4 upper bound 8k (53)");
    send(47,  "R4 lower bound 8k");
    send(30,  "R5 early 8k");

    // bypass by rate select
    set_mode(1'b1, 2'b11);
    send(4, "R3 no-rate select");
    send(9, "R3 no-rate select");
    send(6, "R3 no-rate select");

    // bypass by enable off
    set_mode(1'b0, 2'b00);
    send(3,  "R3 filter off");
    send(15, "R3 filter off");
    send(40, "R3 filter off");

    // re-enable re-arms
    set_mode(1'b1, 2'b00);
    send(12,  "R7 enable re-arm");
    send(100, "R5 early after re-arm");

    repeat (10) @(negedge clk);
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R2 pending: %0d items left expected 0", sbq.size());
    end
    finish_run();
  end

endmodule